// File: doc/BRIEF.md
# SD Card Command-Line Engine

This block owns the bidirectional command wire of a 1-bit or 4-bit SD/MMC host. When it accepts a command, it serialises a 48-bit frame onto the wire. The frame holds a start bit, a transmission bit, the 6-bit command index, the 32-bit argument, a 7-bit CRC and a closing 1. The block then releases the wire and watches it for the card's reply. It captures a per-command number of reply bits and checks their CRC7. It can also hold completion until the card lets DAT0 go high after a busy-signalling reply.

Software-facing logic (or a sequencer) supplies the command word as parallel inputs together with a one-cycle `start` strobe. A separate clock divider supplies two strobes that mark the rising and falling edges of the SD clock. The engine reports a busy level, sticky completion, CRC-good and timeout flags that are cleared by writing ones, and the captured reply bits. Data-line transfers, DMA and the divider itself sit outside.

Top module: `cmd_line_engine`

## Requirements
- R1: After an accepted start, the engine drives 48 bits on 48 consecutive fall strobes. The order is 0, 1, index MSB first, argument MSB first, then the CRC7 MSB first, then 1. The CRC7 uses x^7+x^3+1, starts from zero and covers the first 40 bits. On the 49th fall strobe `cmdOe` drops and `cmdOut` returns to 1. Whenever `cmdOe` is low, `cmdOut` is 1.
- R2: The reply starts at the first sample edge on which `cmdIn` is 0. From that edge on, `respLenM1`+1 bits are captured, one per sample edge. `respData` holds them with the last bit at bit 0, earlier bits above it, and zeros above the captured bits. It is cleared when a command is accepted and does not change while idle.
- R3: The sample edge is the rise strobe when `sampleOnFall` is 0 and the fall strobe when it is 1.
- R4: At completion, `crcOk` is set when the 7 reply bits just before the final bit equal the CRC7 of the reply bits that precede them. The checked bits start at reply index 0, or at index 8 when `crcFrom8` is set. Otherwise `crcOk` is cleared.
- R5: With `skipCrc` set, a command that completes sets `crcOk` whatever CRC bits arrive.
- R6: With `waitBusy` set, completion after the final reply bit waits for the first sample edge on which `dat0In` is 1.
- R7: `busy` is high from the cycle after an accepted start until completion. `done` rises in the cycle in which `busy` falls. A `start` while busy is ignored.
- R8: If 64 sample edges pass after the wire is released without a 0 on `cmdIn`, `timeout` is set, `busy` falls and `done` stays unchanged.
- R9: With `respNone` set, the command completes on the fall strobe that releases the wire, and `crcOk` takes the value of `skipCrc`.
- R10: `statusClr` bit 0 clears `done`, bit 1 clears `crcOk` and bit 2 clears `timeout`. A set in the same cycle wins over the clear.
- R11: `softRst` returns the engine to idle in the next cycle. The wire is released (`cmdOe` 0, `cmdOut` 1), `busy` falls, and the status flags keep their values.
- R12: After reset, `cmdOut` is 1, `cmdOe` is 0, `busy`, `done`, `crcOk` and `timeout` are 0, and `respData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sdRise | input | 1 | One-cycle strobe: SD clock rising edge |
| sdFall | input | 1 | One-cycle strobe: SD clock falling edge |
| sampleOnFall | input | 1 | Sample the reply on fall strobes instead of rise strobes |
| softRst | input | 1 | Abort to idle |
| start | input | 1 | Accept the command word (idle only) |
| cmdIndex | input | 6 | Command index |
| cmdArg | input | 32 | Command argument |
| respLenM1 | input | 8 | Reply bits to capture minus one |
| respNone | input | 1 | Command has no reply |
| crcFrom8 | input | 1 | Start the reply CRC check at reply bit 8 |
| skipCrc | input | 1 | Treat the reply CRC as good |
| waitBusy | input | 1 | Wait for DAT0 high before completing |
| statusClr | input | 3 | Write-one-to-clear: [0] done, [1] crcOk, [2] timeout |
| cmdIn | input | 1 | Command wire as seen at the pad |
| dat0In | input | 1 | DAT0 wire as seen at the pad |
| cmdOut | output | 1 | Command wire drive value |
| cmdOe | output | 1 | Command wire output enable |
| respData | output | 136 | Captured reply bits |
| busy | output | 1 | Command in flight |
| done | output | 1 | Sticky completion flag (interrupt) |
| crcOk | output | 1 | Sticky reply-CRC-good flag |
| timeout | output | 1 | Sticky no-reply flag |

## Verification
A wrong bit counter or a lost frame bit shows on `cmdOut` at the very next fall strobe. The reference model tracks the wire bit by bit, so the mismatch appears within four clocks. A CRC register that is fed a wrong bit, or skips one, stays hidden until the reply ends, and then `crcOk` disagrees in the completion cycle. A stuck state or a stray start shows at once on `busy`, and a bad capture shift shows on `respData` on the next sample edge.

// File: rtl/cmd_line_pkg.sv
package cmd_line_pkg;

  localparam int CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;  // x^7 + x^3 + 1

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_WAIT,
    ST_RECV,
    ST_BUSY
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch a new frame, clear reply and rx crc
    logic shiftOut;  // drive next frame bit
    logic idleLine;  // release the wire
    logic capture;   // shift cmdIn into the reply register
    logic crcEn;     // feed cmdIn into the rx crc
    logic clear;     // abort: release the wire
  } dp_ctl_t;

  function automatic logic [CRC_W-1:0] crc7Step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : {CRC_W{1'b0}});
  endfunction

endpackage

// File: rtl/cmd_line_dp.sv
module cmd_line_dp
  import cmd_line_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ARG_W  = 32,
  parameter int RESP_W = 136
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [ARG_W-1:0]  cmdArg,
  input  logic              cmdIn,
  output logic              cmdOut,
  output logic              cmdOe,
  output logic [RESP_W-1:0] respData,
  output logic              rxCrcZero
);

  localparam int MSG_W   = 2 + IDX_W + ARG_W;
  localparam int FRAME_W = MSG_W + CRC_W + 1;

  logic [MSG_W-1:0]   msg;
  logic [CRC_W-1:0]   txCrc;
  logic [FRAME_W-1:0] frameSr;
  logic [RESP_W-1:0]  respSr;
  logic [CRC_W-1:0]   crcRx;
  logic               cmdOutQ;
  logic               cmdOeQ;

  assign msg = {2'b01, cmdIndex, cmdArg};

  // unrolled CRC over the message, one stage per bit, MSB first
  for (genvar g = 0; g < MSG_W; g++) begin : gCrc
    logic [CRC_W-1:0] c;
    if (g == 0) begin : gFirst
      assign c = crc7Step({CRC_W{1'b0}}, msg[MSG_W-1]);
    end else begin : gNext
      assign c = crc7Step(gCrc[g-1].c, msg[MSG_W-1-g]);
    end
  end
  assign txCrc = gCrc[MSG_W-1].c;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSr <= '0;
      respSr  <= '0;
      crcRx   <= '0;
      cmdOutQ <= 1'b1;
      cmdOeQ  <= 1'b0;
    end else if (ctl.clear) begin
      cmdOutQ <= 1'b1;
      cmdOeQ  <= 1'b0;
    end else if (ctl.load) begin
      frameSr <= {msg, txCrc, 1'b1};
      respSr  <= '0;
      crcRx   <= '0;
    end else begin
      if (ctl.shiftOut) begin
        cmdOutQ <= frameSr[FRAME_W-1];
        cmdOeQ  <= 1'b1;
        frameSr <= {frameSr[FRAME_W-2:0], 1'b0};
      end
      if (ctl.idleLine) begin
        cmdOutQ <= 1'b1;
        cmdOeQ  <= 1'b0;
      end
      if (ctl.capture) respSr <= {respSr[RESP_W-2:0], cmdIn};
      if (ctl.crcEn)   crcRx  <= crc7Step(crcRx, cmdIn);
    end
  end

  assign cmdOut    = cmdOutQ;
  assign cmdOe     = cmdOeQ;
  assign respData  = respSr;
  assign rxCrcZero = (crcRx == '0);

endmodule

// File: rtl/cmd_line_ctrl.sv
module cmd_line_ctrl
  import cmd_line_pkg::*;
#(
  parameter int LEN_W        = 8,
  parameter int FRAME_W      = 48,
  parameter int RESP_TIMEOUT = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdRise,
  input  logic             sdFall,
  input  logic             sampleOnFall,
  input  logic             softRst,
  input  logic             start,
  input  logic [LEN_W-1:0] respLenM1,
  input  logic             respNone,
  input  logic             crcFrom8,
  input  logic             skipCrc,
  input  logic             waitBusy,
  input  logic [2:0]       statusClr,
  input  logic             cmdIn,
  input  logic             dat0In,
  input  logic             rxCrcZero,
  output dp_ctl_t          ctl,
  output logic             busy,
  output logic             done,
  output logic             crcOk,
  output logic             timeout
);

  localparam int FCNT_W = $clog2(FRAME_W + 1);
  localparam int CNT_W  = (LEN_W > FCNT_W) ? LEN_W : FCNT_W;
  localparam int TO_W   = $clog2(RESP_TIMEOUT);

  phase_t           state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;
  logic [TO_W-1:0]  waitCnt, waitCntNxt;
  logic [LEN_W-1:0] lenQ;
  logic             noRespQ, from8Q, skipQ, busyWaitQ;
  logic             crcPendQ, crcPendNxt;
  logic             doneQ, crcOkQ, toQ;
  logic             sampleEn, capStep, finish, finishOk, toHit, accept;
  logic [CNT_W-1:0] lenExt, startIdx;

  assign sampleEn = sampleOnFall ? sdFall : sdRise;
  assign lenExt   = CNT_W'(lenQ);
  assign startIdx = from8Q ? CNT_W'(8) : '0;
  assign accept   = (state == ST_IDLE) && start && !softRst;

  always_comb begin
    ctl        = '0;
    stateNxt   = state;
    bitCntNxt  = bitCnt;
    waitCntNxt = waitCnt;
    crcPendNxt = crcPendQ;
    capStep    = 1'b0;
    finish     = 1'b0;
    finishOk   = crcPendQ;
    toHit      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          stateNxt  = ST_SEND;
          bitCntNxt = '0;
        end
      end
      ST_SEND: begin
        if (sdFall) begin
          if (bitCnt == CNT_W'(FRAME_W)) begin
            ctl.idleLine = 1'b1;
            bitCntNxt    = '0;
            if (noRespQ) begin
              finish   = 1'b1;
              finishOk = skipQ;
            end else begin
              stateNxt   = ST_WAIT;
              waitCntNxt = '0;
            end
          end else begin
            ctl.shiftOut = 1'b1;
            bitCntNxt    = bitCnt + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (sampleEn) begin
          if (!cmdIn)                                  capStep    = 1'b1;
          else if (waitCnt == TO_W'(RESP_TIMEOUT - 1)) toHit      = 1'b1;
          else                                         waitCntNxt = waitCnt + 1'b1;
        end
      end
      ST_RECV: begin
        if (sampleEn) capStep = 1'b1;
      end
      ST_BUSY: begin
        if (sampleEn && dat0In) finish = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase

    if (capStep) begin
      ctl.capture = 1'b1;
      ctl.crcEn   = (bitCnt >= startIdx) && (bitCnt < lenExt);
      if (bitCnt == lenExt) begin
        crcPendNxt = skipQ | rxCrcZero;
        if (busyWaitQ) begin
          stateNxt = ST_BUSY;
        end else begin
          finish   = 1'b1;
          finishOk = skipQ | rxCrcZero;
        end
      end else begin
        stateNxt  = ST_RECV;
        bitCntNxt = bitCnt + 1'b1;
      end
    end

    if (finish || toHit) stateNxt = ST_IDLE;

    if (softRst) begin
      ctl       = '0;
      ctl.clear = 1'b1;
      stateNxt  = ST_IDLE;
      finish    = 1'b0;
      toHit     = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      waitCnt   <= '0;
      lenQ      <= '0;
      noRespQ   <= 1'b0;
      from8Q    <= 1'b0;
      skipQ     <= 1'b0;
      busyWaitQ <= 1'b0;
      crcPendQ  <= 1'b0;
      doneQ     <= 1'b0;
      crcOkQ    <= 1'b0;
      toQ       <= 1'b0;
    end else begin
      state    <= stateNxt;
      bitCnt   <= bitCntNxt;
      waitCnt  <= waitCntNxt;
      crcPendQ <= crcPendNxt;
      if (accept) begin
        lenQ      <= respLenM1;
        noRespQ   <= respNone;
        from8Q    <= crcFrom8;
        skipQ     <= skipCrc;
        busyWaitQ <= waitBusy;
      end
      if (finish) begin
        doneQ  <= 1'b1;
        crcOkQ <= finishOk;
      end else begin
        if (statusClr[0]) doneQ  <= 1'b0;
        if (statusClr[1]) crcOkQ <= 1'b0;
      end
      if (toHit)             toQ <= 1'b1;
      else if (statusClr[2]) toQ <= 1'b0;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;
  assign crcOk   = crcOkQ;
  assign timeout = toQ;

endmodule

// File: rtl/cmd_line_engine.sv
module cmd_line_engine
  import cmd_line_pkg::*;
#(
  parameter int IDX_W        = 6,
  parameter int ARG_W        = 32,
  parameter int LEN_W        = 8,
  parameter int RESP_W       = 136,
  parameter int RESP_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdRise,
  input  logic              sdFall,
  input  logic              sampleOnFall,
  input  logic              softRst,
  input  logic              start,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [ARG_W-1:0]  cmdArg,
  input  logic [LEN_W-1:0]  respLenM1,
  input  logic              respNone,
  input  logic              crcFrom8,
  input  logic              skipCrc,
  input  logic              waitBusy,
  input  logic [2:0]        statusClr,
  input  logic              cmdIn,
  input  logic              dat0In,
  output logic              cmdOut,
  output logic              cmdOe,
  output logic [RESP_W-1:0] respData,
  output logic              busy,
  output logic              done,
  output logic              crcOk,
  output logic              timeout
);

  localparam int FRAME_W = 2 + IDX_W + ARG_W + CRC_W + 1;

  dp_ctl_t ctl;
  logic    rxCrcZero;

  cmd_line_ctrl #(
    .LEN_W(LEN_W), .FRAME_W(FRAME_W), .RESP_TIMEOUT(RESP_TIMEOUT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sdRise(sdRise), .sdFall(sdFall),
    .sampleOnFall(sampleOnFall), .softRst(softRst), .start(start),
    .respLenM1(respLenM1), .respNone(respNone), .crcFrom8(crcFrom8),
    .skipCrc(skipCrc), .waitBusy(waitBusy), .statusClr(statusClr),
    .cmdIn(cmdIn), .dat0In(dat0In), .rxCrcZero(rxCrcZero), .ctl(ctl),
    .busy(busy), .done(done), .crcOk(crcOk), .timeout(timeout)
  );

  cmd_line_dp #(
    .IDX_W(IDX_W), .ARG_W(ARG_W), .RESP_W(RESP_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdIndex(cmdIndex), .cmdArg(cmdArg),
    .cmdIn(cmdIn), .cmdOut(cmdOut), .cmdOe(cmdOe), .respData(respData),
    .rxCrcZero(rxCrcZero)
  );

endmodule

// File: rtl/cmd_line_chk.sv
module cmd_line_chk #(
  parameter int RESP_W = 136
) (
  input logic              clk,
  input logic              rstN,
  input logic              softRst,
  input logic              start,
  input logic              clrDone,
  input logic              cmdOut,
  input logic              cmdOe,
  input logic [RESP_W-1:0] respData,
  input logic              busy,
  input logic              done,
  input logic              timeout
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !cmdOe |-> cmdOut);  // R1

  AST_FRAME_STARTS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdOe) |-> !cmdOut);  // R1

  AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cmdOe |-> busy);  // R7

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !busy);  // R7

  AST_RESP_HELD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(respData));  // R2

  AST_TIMEOUT_NOT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeout) |-> !$rose(done));  // R8

  AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (clrDone && !busy) |=> !done);  // R10

  AST_SOFT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!busy && !cmdOe));  // R11

endmodule

bind cmd_line_engine cmd_line_chk #(.RESP_W(RESP_W)) uChk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .start(start),
  .clrDone(statusClr[0]), .cmdOut(cmdOut), .cmdOe(cmdOe),
  .respData(respData), .busy(busy), .done(done), .timeout(timeout)
);

// File: tb/tb_cmd_line_engine.sv
module tb_cmd_line_engine;
  localparam int RESP_W = 136;

  logic clk = 1'b0;
  always #5 clk = ~clk;  // 100 MHz

  logic rstN = 1'b0;
  logic [1:0] ph = 2'd0;
  logic sdRise = 1'b0, sdFall = 1'b0;
  always @(posedge clk) begin
    ph     <= ph + 2'd1;
    sdRise <= (ph == 2'd3);
    sdFall <= (ph == 2'd1);
  end

  logic        sampleOnFall = 0, softRst = 0, start = 0;
  logic [5:0]  cmdIndex = 0;
  logic [31:0] cmdArg = 0;
  logic [7:0]  respLenM1 = 0;
  logic        respNone = 0, crcFrom8 = 0, skipCrc = 0, waitBusy = 0;
  logic [2:0]  statusClr = 0;
  logic        cmdIn = 1, dat0In = 1;
  logic        cmdOut, cmdOe, busy, done, crcOk, timeout;
  logic [RESP_W-1:0] respData;

  cmd_line_engine dut (
    .clk(clk), .rstN(rstN), .sdRise(sdRise), .sdFall(sdFall),
    .sampleOnFall(sampleOnFall), .softRst(softRst), .start(start),
    .cmdIndex(cmdIndex), .cmdArg(cmdArg), .respLenM1(respLenM1),
    .respNone(respNone), .crcFrom8(crcFrom8), .skipCrc(skipCrc),
    .waitBusy(waitBusy), .statusClr(statusClr), .cmdIn(cmdIn),
    .dat0In(dat0In), .cmdOut(cmdOut), .cmdOe(cmdOe), .respData(respData),
    .busy(busy), .done(done), .crcOk(crcOk), .timeout(timeout)
  );

  int nTests = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [RESP_W-1:0] act, input logic [RESP_W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  // polynomial long division: remainder of wq(x)*x^7 mod x^7+x^3+1
  bit wq[$];
  function automatic logic [6:0] crc7OfWq();
    bit v[$];
    logic [6:0] r;
    v = wq;
    for (int k = 0; k < 7; k++) v.push_back(1'b0);
    for (int i = 0; i + 7 < v.size(); i++)
      if (v[i]) begin v[i] ^= 1'b1; v[i+4] ^= 1'b1; v[i+7] ^= 1'b1; end
    for (int k = 0; k < 7; k++) r[6-k] = v[v.size()-7+k];
    return r;
  endfunction

  // ---------------- behavioural reference model ----------------
  int  mPh = 0;           // 0 idle, 1 sending, 2 waiting, 3 receiving, 4 dat0 wait
  bit  txQ[$], rxQ[$];
  int  waitEdges = 0;
  int  oLen = 0;
  bit  oNone = 0, oFrom8 = 0, oSkip = 0, oBusy = 0, pendOk = 0;
  bit  eOut = 1, eOe = 0, eDone = 0, eCrcOk = 0, eTo = 0;
  logic [RESP_W-1:0] eResp = '0;
  bit  setDone = 0, setTo = 0, okVal = 0;

  task automatic complete(input bit ok);
    setDone = 1; okVal = ok; mPh = 0;
  endtask

  task automatic takeBit();
    logic [6:0] c;
    rxQ.push_back(cmdIn);
    eResp = {eResp[RESP_W-2:0], cmdIn};
    if (rxQ.size() == oLen + 1) begin
      wq.delete();
      for (int i = (oFrom8 ? 8 : 0); i < oLen; i++) wq.push_back(rxQ[i]);
      c = crc7OfWq();
      pendOk = oSkip || (c == 7'd0);
      if (oBusy) mPh = 4; else complete(pendOk);
    end else mPh = 3;
  endtask

  always @(posedge clk) begin
    bit se;
    logic [6:0] c;
    setDone = 0; setTo = 0;
    if (!rstN) begin
      mPh = 0; eOut = 1; eOe = 0; eDone = 0; eCrcOk = 0; eTo = 0; eResp = '0;
    end else begin
      se = sampleOnFall ? sdFall : sdRise;
      if (softRst) begin
        mPh = 0; eOe = 0; eOut = 1;
      end else begin
        case (mPh)
          0: if (start) begin
            wq.delete();
            wq.push_back(0); wq.push_back(1);
            for (int i = 5; i >= 0; i--)  wq.push_back(cmdIndex[i]);
            for (int i = 31; i >= 0; i--) wq.push_back(cmdArg[i]);
            c = crc7OfWq();
            txQ = wq;
            for (int i = 6; i >= 0; i--) txQ.push_back(c[i]);
            txQ.push_back(1);
            rxQ.delete(); eResp = '0;
            oLen = respLenM1; oNone = respNone; oFrom8 = crcFrom8;
            oSkip = skipCrc; oBusy = waitBusy;
            mPh = 1;
          end
          1: if (sdFall) begin
            if (txQ.size() > 0) begin eOut = txQ.pop_front(); eOe = 1; end
            else begin
              eOe = 0; eOut = 1;
              if (oNone) complete(oSkip); else begin mPh = 2; waitEdges = 0; end
            end
          end
          2: if (se) begin
            if (cmdIn == 1'b0) takeBit();
            else begin
              waitEdges++;
              if (waitEdges == 64) begin setTo = 1; mPh = 0; end
            end
          end
          3: if (se) takeBit();
          4: if (se && dat0In) complete(pendOk);
          default: mPh = 0;
        endcase
      end
      if (setDone) begin eDone = 1; eCrcOk = okVal; end
      else begin
        if (statusClr[0]) eDone = 0;
        if (statusClr[1]) eCrcOk = 0;
      end
      if (setTo) eTo = 1; else if (statusClr[2]) eTo = 0;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) if (!finished) begin
    chk("R1 cmdOut", cmdOut, eOut);
    chk("R1 cmdOe", cmdOe, eOe);
    chk("R2/R3 respData", respData, eResp);
    chk("R7 busy", busy, mPh != 0);
    chk("R7/R6/R9 done", done, eDone);
    chk("R4/R5 crcOk", crcOk, eCrcOk);
    chk("R8 timeout", timeout, eTo);
  end

  // ---------------- card side ----------------
  bit cardQ[$];
  task automatic waitFall();
    do @(negedge clk); while (!sdFall);
    @(negedge clk);
  endtask

  task automatic card(input int gap);
    while (!cmdOe) @(negedge clk);
    while (cmdOe) @(negedge clk);
    repeat (gap) waitFall();
    foreach (cardQ[i]) begin waitFall(); cmdIn = cardQ[i]; end
    waitFall();
    cmdIn = 1'b1;
  endtask

  task automatic buildResp(input logic [5:0] idx, input logic [31:0] pay, input bit longResp, input bit corrupt);
    logic [6:0] c;
    wq.delete();
    if (longResp) begin
      for (int i = 0; i < 120; i++) wq.push_back(pay[i % 32] ^ (i % 3 == 0));
    end else begin
      wq.push_back(0); wq.push_back(0);
      for (int i = 5; i >= 0; i--)  wq.push_back(idx[i]);
      for (int i = 31; i >= 0; i--) wq.push_back(pay[i]);
    end
    c = crc7OfWq();
    cardQ.delete();
    if (longResp) begin
      cardQ.push_back(0); cardQ.push_back(0);
      for (int i = 0; i < 6; i++) cardQ.push_back(1);
    end
    foreach (wq[i]) cardQ.push_back(wq[i]);
    for (int i = 6; i >= 0; i--) cardQ.push_back(c[i]);
    cardQ.push_back(1);
    if (corrupt) cardQ[20] = ~cardQ[20];
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input bit longResp,
                       input bit none, input bit skip, input bit wb);
    @(negedge clk);
    cmdIndex = idx; cmdArg = arg; respLenM1 = longResp ? 8'd135 : 8'd47;
    crcFrom8 = longResp; respNone = none; skipCrc = skip; waitBusy = wb;
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finishCmd(input string req, input bit expDone, input bit expOk, input bit expTo);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk({req, " final done"}, done, expDone);
    chk({req, " final crcOk"}, crcOk, expOk);
    chk({req, " final timeout"}, timeout, expTo);
    statusClr = 3'b111;
    @(negedge clk);
    statusClr = 3'b000;
    chk("R10 flags cleared", {done, crcOk, timeout}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset line", {cmdOut, cmdOe}, 2'b10);
    chk("R12 reset flags", {busy, done, crcOk, timeout}, 4'b0000);
    chk("R12 reset respData", respData, '0);
    rstN = 1;
    repeat (4) @(negedge clk);

    // R1 R2 R4: short reply, good CRC, rise sampling
    buildResp(6'd17, 32'h1234_5678, 0, 0);
    issue(6'd17, 32'hDEAD_BEEF, 0, 0, 0, 0);
    card(2);
    finishCmd("R4 good", 1, 1, 0);

    // R4: corrupted reply bit
    buildResp(6'd8, 32'h0000_01AA, 0, 1);
    issue(6'd8, 32'h0000_01AA, 0, 0, 0, 0);
    card(1);
    finishCmd("R4 bad", 1, 0, 0);

    // R5: same corruption, check bypassed
    buildResp(6'd8, 32'h0000_01AA, 0, 1);
    issue(6'd8, 32'h0000_01AA, 0, 0, 1, 0);
    card(1);
    finishCmd("R5 skip", 1, 1, 0);

    // R2 R4: 136-bit reply, CRC from bit 8
    buildResp(6'd2, 32'hC0FF_EE11, 1, 0);
    issue(6'd2, 32'h0, 1, 0, 0, 0);
    card(3);
    finishCmd("R4 long", 1, 1, 0);

    // R3: sample on fall strobes
    sampleOnFall = 1;
    buildResp(6'd55, 32'h8000_0001, 0, 0);
    issue(6'd55, 32'h0000_FFFF, 0, 0, 0, 0);
    card(0);
    finishCmd("R3 fall", 1, 1, 0);
    sampleOnFall = 0;

    // R6: DAT0 busy hold
    dat0In = 0;
    buildResp(6'd7, 32'h0000_0900, 0, 0);
    issue(6'd7, 32'h0001_0000, 0, 0, 0, 1);
    card(1);
    repeat (12) @(negedge clk);
    chk("R6 still busy while DAT0 low", busy, 1'b1);
    repeat (20) @(negedge clk);
    dat0In = 1;
    finishCmd("R6 busy", 1, 1, 0);

    // R8: no reply at all
    issue(6'd5, 32'h0, 0, 0, 0, 0);
    finishCmd("R8 timeout", 0, 0, 1);

    // R9: no reply expected
    issue(6'd0, 32'h0, 0, 1, 0, 0);
    finishCmd("R9 none", 1, 0, 0);
    issue(6'd0, 32'h0, 0, 1, 1, 0);
    finishCmd("R9 none skip", 1, 1, 0);

    // R7: start while busy is ignored
    buildResp(6'd13, 32'h0000_0A5A, 0, 0);
    issue(6'd13, 32'h0000_0A5A, 0, 0, 0, 0);
    repeat (30) @(negedge clk);
    cmdIndex = 6'd40; cmdArg = 32'hFFFF_0000; respNone = 1; start = 1;
    @(negedge clk);
    start = 0;
    card(1);
    finishCmd("R7 poke", 1, 1, 0);

    // R11: soft reset during reply
    buildResp(6'd9, 32'h7777_1111, 0, 0);
    issue(6'd9, 32'h0, 0, 0, 0, 0);
    fork
      card(1);
      begin
        while (!cmdOe) @(negedge clk);
        while (cmdOe) @(negedge clk);
        repeat (60) @(negedge clk);
        softRst = 1;
        @(negedge clk);
        softRst = 0;
        chk("R11 idle after abort", {busy, cmdOe, cmdOut}, 3'b001);
        chk("R11 flags kept", {done, timeout}, 2'b00);
      end
    join
    repeat (10) @(negedge clk);
    chk("R11 stays idle", busy, 1'b0);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired (R7 busy never ended) actual=hung expected=finished");
      finishRun();
    end
  end

endmodule